// File: doc/BRIEF.md
# Descriptor-Driven Configuration Item Transfer Engine

This block is a bus master that runs one transfer per in-memory descriptor against a small internal table of configuration items. The host places a 16-byte descriptor in memory, then hands its 64-bit address to the engine through an 8-byte register window. The address goes in either as two 32-bit halves, upper first, or as one 64-bit write. Storing the lower half, or the whole address, starts the transfer. Reads of the window return slices of a fixed 8-byte identification constant.

The engine fetches the descriptor as four big-endian 32-bit beats. It can switch the selected item first. It then copies item bytes to memory, skips over them, or validates a write request. The transfer ends when the engine writes a completion word (0 for success, 1 for error) over the descriptor's control field. The item table is computed rather than stored. The selected key and the read offset persist from one descriptor to the next, so the host can stream an item in pieces.

Top module: `cfg_dma_engine`

## Requirements
- R1: After reset the engine is idle (busy low, no bus request), the selected key is 0 and the item offset is 0. A read descriptor without the select bit therefore operates on item 0, which has length 0.
- R2: Register writes are accepted only while idle:
  - A 4-byte write at window offset 0 loads the upper address half and clears the lower half. It does not start a transfer.
  - A 4-byte write at offset 4 ORs its data into the lower half and starts a transfer.
  - An 8-byte write at offset 0 loads the full address and starts a transfer.
  - Any other size or offset has no effect.
  - Starting a transfer clears the held address to zero.
- R3: A read of the window with byte size s at offset o returns bytes o..o+s-1 of the 64-bit constant SIGNATURE as a big-endian number, where byte 0 is bits 63:56. If o+s exceeds 8, the read returns 0.
- R4: The descriptor is fetched as 32-bit word reads at descriptor address +0, +4, +8 and +12, in that order. The byte at the lowest address of each word is its most significant byte. The descriptor fields are:
  - control word at +0;
  - length at +4;
  - upper half of the target address at +8;
  - lower half of the target address at +12.
- R5: Control word bit positions are: 1 read, 2 skip, 3 select, 4 write, bits 31:16 key. Read takes priority over write, and write takes priority over skip. If none of the three is set, the length is treated as zero and no data moves.
- R6: When the select bit is set, bits 31:16 become the selected key and the item offset returns to 0, before any data movement. Without the select bit, the key and offset carry over from the previous transfer.
- R7: The item table works as follows:
  - Key k is valid when k < ITEMS.
  - A valid item has length LEN_STEP*k.
  - Byte j of item k is (37*k + 5*j + 1) mod 256.
  - A read writes one byte per bus write to consecutive target addresses, using item bytes while any remain and zeros after that (always zeros for an invalid key). The offset advances by the item bytes consumed.
- R8: A skip advances the offset by the smaller of the length and the remaining item bytes, and performs no memory writes.
- R9: A write moves no data. It completes without error only if the key is valid, the item has bytes remaining, the key is odd (writable) and the length does not exceed the remaining bytes. Otherwise it sets error. When bytes remained, the offset advances by the smaller of length and remaining bytes.
- R10: A bus error on a descriptor fetch beat or a data byte write sets error and stops the transfer.
- R11: Every transfer ends with one 32-bit write of 0 or 1 (big-endian) to the descriptor's control field. busy stays high from the start until that write is accepted.
- R12: Start requests that arrive while busy are ignored and cause no further transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register window write strobe |
| reg_off | input | 3 | Byte offset of the access in the window |
| reg_size | input | 4 | Access size in bytes (1, 2, 4 or 8) |
| reg_wdata | input | 64 | Write data, right-aligned |
| reg_rdata | output | 64 | Identification constant slice, right-aligned |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory request, held until mem_ready |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_byte | output | 1 | 1 = single-byte access on bits 7:0, 0 = 32-bit word |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 32 | Write data, lowest address in bits 31:24 for words |
| mem_ready | input | 1 | Request accepted and completed this cycle |
| mem_err | input | 1 | Bus error, valid with mem_ready |
| mem_rdata | input | 32 | Read word, lowest address in bits 31:24 |

## Verification
The assertions check the following on every cycle:
- a pending request holds its address, direction and data steady until it is accepted;
- requests occur only while busy;
- byte writes carry only an 8-bit value;
- descriptor reads are whole words;
- the only word ever written is a 0-or-1 completion code;
- busy drops only right after that completion write is accepted.

Some behaviour cannot be seen in a single cycle, so only the bench's scenarios show it. This covers the item contents landing at the right addresses, and the zero fill past the end of an item. It also covers the carried-over key and offset across descriptors, the read/write/skip priority, and the write acceptance rules. Finally it covers the address-clearing side effect of a start and the dropping of start requests while busy.

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine #(
  parameter int ITEMS = 8,
  parameter int LEN_STEP = 3,
  parameter logic [63:0] SIGNATURE = 64'h4346_475F_444D_4131
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_off,
  input  logic [3:0]  reg_size,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic        busy,
  output logic        mem_req,
  output logic        mem_we,
  output logic        mem_byte,
  output logic [63:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ready,
  input  logic        mem_err,
  input  logic [31:0] mem_rdata
);
  localparam logic [3:0] WORD_BYTES = 4'd4;
  localparam logic [3:0] WIDE_BYTES = 4'd8;
  localparam logic [7:0] KEY_MUL = 8'd37;
  localparam logic [7:0] OFF_MUL = 8'd5;
  localparam logic [7:0] BYTE_SEED = 8'd1;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_EXEC, S_MOVE, S_STAT} state_t;
  typedef enum logic [1:0] {M_NONE, M_READ, M_WRITE, M_SKIP} mode_t;

  state_t st;
  mode_t  mode;
  logic [63:0] addr_reg, desc_q, tgt_q;
  logic [31:0] len_q, off_q;
  logic [15:0] key_q, new_key_q;
  logic [3:0]  flags_q;
  logic [1:0]  beat;
  logic        err_q;

  assign busy = (st != S_IDLE);

  wire wr_hi   = reg_wr && !busy && reg_size == WORD_BYTES && reg_off == 3'd0;
  wire wr_lo   = reg_wr && !busy && reg_size == WORD_BYTES && reg_off == 3'd4;
  wire wr_full = reg_wr && !busy && reg_size == WIDE_BYTES && reg_off == 3'd0;

  wire [3:0] room = 4'd8 - {1'b0, reg_off} - reg_size;
  always_comb begin
    reg_rdata = 64'h0;
    if (reg_size != 4'd0 && ({1'b0, reg_off} + reg_size) <= 4'd8)
      reg_rdata = (SIGNATURE >> {room, 3'b000}) &
                  ((reg_size == WIDE_BYTES) ? {64{1'b1}} : ~({64{1'b1}} << {reg_size, 3'b000}));
  end

  wire        key_ok    = 32'(key_q) < 32'(ITEMS);
  wire [31:0] item_len  = key_ok ? 32'(key_q) * 32'(LEN_STEP) : 32'd0;
  wire        avail     = off_q < item_len;
  wire [31:0] remain    = item_len - off_q;
  wire [31:0] chunk     = (len_q <= remain) ? len_q : remain;
  wire [7:0]  item_byte = key_q[7:0] * KEY_MUL + off_q[7:0] * OFF_MUL + BYTE_SEED;
  wire        done      = (len_q == 32'd0) || err_q;
  wire        acc       = mem_req && mem_ready;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_byte  = 1'b0;
    mem_addr  = desc_q;
    mem_wdata = 32'h0;
    case (st)
      S_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = desc_q + {59'h0, beat, 3'b000} / 64'd2;
      end
      S_MOVE: if (!done && mode == M_READ) begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_byte  = 1'b1;
        mem_addr  = tgt_q;
        mem_wdata = {24'h0, avail ? item_byte : 8'h00};
      end
      S_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {31'h0, err_q};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      mode      <= M_NONE;
      addr_reg  <= 64'h0;
      desc_q    <= 64'h0;
      tgt_q     <= 64'h0;
      len_q     <= 32'h0;
      off_q     <= 32'h0;
      key_q     <= 16'h0;
      new_key_q <= 16'h0;
      flags_q   <= 4'h0;
      beat      <= 2'd0;
      err_q     <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (wr_hi) addr_reg <= {reg_wdata[31:0], 32'h0};
          if (wr_lo || wr_full) begin
            desc_q   <= wr_full ? reg_wdata
                                : {addr_reg[63:32], addr_reg[31:0] | reg_wdata[31:0]};
            addr_reg <= 64'h0;
            beat     <= 2'd0;
            err_q    <= 1'b0;
            st       <= S_FETCH;
          end
        end
        S_FETCH: if (acc) begin
          if (mem_err) begin
            err_q <= 1'b1;
            st    <= S_STAT;
          end else begin
            case (beat)
              2'd0: begin
                new_key_q <= mem_rdata[31:16];
                flags_q   <= mem_rdata[4:1];
              end
              2'd1: len_q <= mem_rdata;
              2'd2: tgt_q[63:32] <= mem_rdata;
              default: begin
                tgt_q[31:0] <= mem_rdata;
                st <= S_EXEC;
              end
            endcase
            beat <= beat + 2'd1;
          end
        end
        S_EXEC: begin
          if (flags_q[2]) begin
            key_q <= new_key_q;
            off_q <= 32'h0;
          end
          if (flags_q[0])      mode <= M_READ;
          else if (flags_q[3]) mode <= M_WRITE;
          else if (flags_q[1]) mode <= M_SKIP;
          else begin
            mode  <= M_NONE;
            len_q <= 32'h0;
          end
          st <= S_MOVE;
        end
        S_MOVE: begin
          if (done) st <= S_STAT;
          else begin
            case (mode)
              M_READ: if (acc) begin
                if (mem_err) err_q <= 1'b1;
                else begin
                  tgt_q <= tgt_q + 64'd1;
                  len_q <= len_q - 32'd1;
                  if (avail) off_q <= off_q + 32'd1;
                end
              end
              M_SKIP: begin
                if (avail) begin
                  tgt_q <= tgt_q + 64'(chunk);
                  len_q <= len_q - chunk;
                  off_q <= off_q + chunk;
                end else begin
                  tgt_q <= tgt_q + 64'(len_q);
                  len_q <= 32'h0;
                end
              end
              M_WRITE: begin
                if (!avail) err_q <= 1'b1;
                else begin
                  off_q <= off_q + chunk;
                  tgt_q <= tgt_q + 64'(chunk);
                  len_q <= len_q - chunk;
                  if (!key_q[0] || len_q > remain) err_q <= 1'b1;
                end
              end
              default: len_q <= 32'h0;
            endcase
          end
        end
        S_STAT: if (acc) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_dma_engine_chk.sv
module cfg_dma_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_byte,
  input logic [63:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ready
);
  // R11
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) &&
                              $stable(mem_byte) && $stable(mem_wdata));

  // R4
  fetch_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> !mem_byte);

  // R7
  byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_byte |-> mem_we && mem_wdata[31:8] == 24'h0);

  // R11
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !mem_byte |-> mem_wdata[31:1] == 31'h0);

  // R11
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mem_req && mem_ready && mem_we && !mem_byte));
endmodule

bind cfg_dma_engine cfg_dma_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
  .mem_byte(mem_byte), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready)
);

// File: tb/cfg_dma_engine_test.sv
module cfg_dma_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int ITEMS = 8;
  localparam int LEN_STEP = 3;
  localparam logic [63:0] SIG = 64'h4346_475F_444D_4131;
  localparam int MEM_BYTES = 256;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_off = 3'd0;
  logic [3:0]  reg_size = 4'd0;
  logic [63:0] reg_wdata = 64'h0;
  logic [63:0] reg_rdata;
  logic        busy, mem_req, mem_we, mem_byte;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ready = 1'b0;
  logic        mem_err = 1'b0;
  logic [31:0] mem_rdata = 32'h0;

  cfg_dma_engine #(.ITEMS(ITEMS), .LEN_STEP(LEN_STEP), .SIGNATURE(SIG)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_off(reg_off), .reg_size(reg_size),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .mem_req(mem_req),
    .mem_we(mem_we), .mem_byte(mem_byte), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_err(mem_err), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0]  mem  [MEM_BYTES];
  logic [7:0]  expm [MEM_BYTES];
  logic [63:0] faddr [4];
  int fcnt = 0, nstat = 0, n_chk = 0, n_fail = 0, cyc = 0;
  logic [15:0] mk = 16'h0;
  logic [31:0] mo = 32'h0;

  // memory model: answers one request every other cycle, errors beyond MEM_BYTES
  always @(negedge clk) begin
    if (mem_ready) mem_ready = 1'b0;
    else if (mem_req && rst_n) begin
      mem_ready = 1'b1;
      if (mem_byte) begin
        mem_err = mem_addr > 64'd255;
        if (!mem_err && mem_we) mem[mem_addr[7:0]] = mem_wdata[7:0];
      end else begin
        mem_err = mem_addr > 64'd252;
        if (mem_we) begin
          nstat = nstat + 1;
          if (!mem_err)
            for (int b = 0; b < 4; b++) mem[mem_addr[7:0] + 8'(b)] = mem_wdata[31-8*b -: 8];
        end else begin
          if (fcnt < 4) faddr[fcnt] = mem_addr;
          fcnt = fcnt + 1;
          mem_rdata = 32'h0;
          if (!mem_err)
            for (int b = 0; b < 4; b++) mem_rdata[31-8*b -: 8] = mem[mem_addr[7:0] + 8'(b)];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] ex);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, ex);
    end
  endtask

  function automatic logic [7:0] ibyte(input logic [15:0] k, input logic [31:0] o);
    return 8'(32'(k) * 37 + o * 5 + 1);
  endfunction

  task automatic put32(input logic [63:0] a, input logic [31:0] v);
    if (a <= 64'd252)
      for (int b = 0; b < 4; b++) begin
        mem[a[7:0] + 8'(b)]  = v[31-8*b -: 8];
        expm[a[7:0] + 8'(b)] = v[31-8*b -: 8];
      end
  endtask

  function automatic logic [31:0] get32e(input logic [63:0] a);
    logic [31:0] v;
    for (int b = 0; b < 4; b++) v[31-8*b -: 8] = expm[a[7:0] + 8'(b)];
    return v;
  endfunction

  // reference of one transfer, built from the requirements
  task automatic model(input logic [63:0] d);
    logic [31:0] c, l, il, ch;
    logic [63:0] t;
    bit e, rd, wr, sk;
    e = 0;
    if (d > 64'd240) e = 1;
    else begin
      c = get32e(d); l = get32e(d + 4); t = {get32e(d + 8), get32e(d + 12)};
      if (c[3]) begin mk = c[31:16]; mo = 0; end
      rd = c[1]; wr = !c[1] && c[4]; sk = !c[1] && !c[4] && c[2];
      if (!rd && !wr && !sk) l = 0;
      while (l != 0 && !e) begin
        il = (32'(mk) < ITEMS) ? 32'(mk) * LEN_STEP : 32'd0;
        ch = (mo >= il) ? l : ((l <= il - mo) ? l : il - mo);
        if (rd) begin
          if (t > 64'd255) e = 1;
          else begin
            expm[t[7:0]] = (mo < il) ? ibyte(mk, mo) : 8'h00;
            if (mo < il) mo++;
            t++; l--;
          end
        end else if (wr) begin
          if (mo >= il || !mk[0] || l > il - mo) e = 1;
          if (mo < il) mo += ch;
          l = 0;
        end else begin
          if (mo < il) mo += ch;
          l -= ch;
        end
      end
    end
    if (d <= 64'd252)
      for (int b = 0; b < 4; b++) expm[d[7:0] + 8'(b)] = (b == 3) ? {7'h0, e} : 8'h00;
  endtask

  task automatic reg_write(input logic [2:0] off, input logic [3:0] size, input logic [63:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_off = off; reg_size = size; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    chk(!busy, req, 64'(busy), 64'h0);
  endtask

  task automatic mem_cmp(input string req);
    int bad = -1;
    for (int i = 0; i < MEM_BYTES; i++) if (bad < 0 && mem[i] !== expm[i]) bad = i;
    if (bad < 0) chk(1'b1, req, 64'h0, 64'h0);
    else chk(1'b0, {req, " memory byte"}, {32'(bad), 24'h0, mem[bad]}, {32'(bad), 24'h0, expm[bad]});
  endtask

  task automatic run(input logic [63:0] d, input logic [31:0] ctl, input logic [31:0] len,
                     input logic [63:0] tgt, input bit wide, input string req);
    put32(d, ctl); put32(d + 4, len); put32(d + 8, tgt[63:32]); put32(d + 12, tgt[31:0]);
    model(d);
    fcnt = 0;
    if (wide) reg_write(3'd0, 4'd8, d);
    else begin
      reg_write(3'd0, 4'd4, {32'h0, d[63:32]});
      reg_write(3'd4, 4'd4, {32'h0, d[31:0]});
    end
    wait_idle(req);
    mem_cmp(req);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WATCHDOG);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] ex;
    for (int i = 0; i < MEM_BYTES; i++) begin
      mem[i] = 8'(i * 7 + 3);
      expm[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", 64'(busy), 64'h0);
    chk(mem_req == 1'b0, "R1 no request after reset", 64'(mem_req), 64'h0);
    rst_n = 1'b1;

    // R3: signature sweep over every offset and size
    for (int o = 0; o < 8; o++)
      for (int si = 0; si < 4; si++) begin
        int s = 1 << si;
        @(negedge clk);
        reg_off = 3'(o); reg_size = 4'(s);
        #1;
        ex = 64'h0;
        if (o + s <= 8)
          for (int b = 0; b < s; b++) ex = (ex << 8) | 64'(SIG[63 - 8*(o+b) -: 8]);
        chk(reg_rdata == ex, "R3 signature read", reg_rdata, ex);
      end

    run(64'h00, 32'h0000_0002, 32'd3, 64'h80, 1'b1, "R1 default item 0 read");
    run(64'h10, 32'h0002_000A, 32'd4, 64'h88, 1'b1, "R7 item 2 read");
    run(64'h20, 32'h0000_0002, 32'd4, 64'h90, 1'b0, "R6 continued read with zero fill");
    run(64'h30, 32'h0020_000A, 32'd3, 64'h98, 1'b1, "R7 invalid key zero fill");
    run(64'h40, 32'h0003_000C, 32'd4, 64'hA0, 1'b1, "R8 skip");
    run(64'h50, 32'h0000_0002, 32'd3, 64'hA8, 1'b1, "R8 read after skip");
    run(64'h00, 32'h0001_001E, 32'd3, 64'hB0, 1'b1, "R5 read wins");
    run(64'h10, 32'h0003_001C, 32'd2, 64'hB8, 1'b1, "R5 write over skip");
    chk(get32e(64'h10) == 32'h0, "R9 accepted write status", 64'(get32e(64'h10)), 64'h0);
    run(64'h20, 32'h0000_0002, 32'd1, 64'hBC, 1'b1, "R9 offset after write");
    run(64'h30, 32'h0002_0008, 32'd5, 64'hC0, 1'b1, "R5 no direction bit");
    run(64'h40, 32'h0000_0002, 32'd1, 64'hC4, 1'b1, "R5 offset untouched");
    run(64'h50, 32'h0002_0018, 32'd2, 64'hC8, 1'b1, "R9 even key write");
    chk(mem[8'h53] == 8'h01, "R9 even key error status", 64'(mem[8'h53]), 64'h1);
    run(64'h00, 32'h0001_0018, 32'd4, 64'hC8, 1'b1, "R9 write longer than item");
    run(64'h10, 32'h0000_0002, 32'd1, 64'hCC, 1'b1, "R9 offset advanced on error");
    run(64'h20, 32'h0005_0018, 32'd15, 64'hD0, 1'b1, "R9 full-length write");
    run(64'h30, 32'h0040_0018, 32'd1, 64'hD0, 1'b1, "R9 invalid key write");
    run(64'h40, 32'h0004_000A, 32'd4, 64'hFE, 1'b1, "R10 data bus error");
    chk(mem[8'h43] == 8'h01, "R10 data error status", 64'(mem[8'h43]), 64'h1);
    run(64'hF8, 32'h0004_000A, 32'd4, 64'h80, 1'b1, "R10 fetch bus error");
    run(64'h1_0000_0000, 32'h0, 32'd0, 64'h0, 1'b1, "R10 unmapped descriptor");

    // R2: split address halves, clearing on start, ignored shapes
    reg_write(3'd0, 4'd4, 64'h1);
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R2 upper half write does not start", 64'(busy), 64'h0);
    model(64'h1_0000_0020);
    fcnt = 0;
    reg_write(3'd4, 4'd4, 64'h20);
    wait_idle("R2 combined address");
    chk(faddr[0] == 64'h1_0000_0020, "R2 combined address", faddr[0], 64'h1_0000_0020);
    mem_cmp("R2 combined address");
    put32(64'h40, 32'h0006_000A); put32(64'h44, 32'd2); put32(64'h48, 32'h0); put32(64'h4C, 32'hD8);
    model(64'h40);
    fcnt = 0;
    reg_write(3'd4, 4'd4, 64'h40);
    wait_idle("R2 address cleared");
    chk(faddr[0] == 64'h40, "R2 address cleared at start", faddr[0], 64'h40);
    chk(faddr[1] == 64'h44, "R4 fetch order beat 1", faddr[1], 64'h44);
    chk(faddr[2] == 64'h48, "R4 fetch order beat 2", faddr[2], 64'h48);
    chk(faddr[3] == 64'h4C, "R4 fetch order beat 3", faddr[3], 64'h4C);
    mem_cmp("R7 item 6 read");
    reg_write(3'd4, 4'd2, 64'h40);
    reg_write(3'd2, 4'd4, 64'h40);
    reg_write(3'd4, 4'd8, 64'h40);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R2 other shapes do not start", 64'(busy), 64'h0);
    mem_cmp("R2 other shapes do not start");

    // R12: start requests while busy are dropped
    put32(64'h50, 32'h0007_000A); put32(64'h54, 32'd16); put32(64'h58, 32'h0); put32(64'h5C, 32'hE0);
    put32(64'h60, 32'h0001_000A); put32(64'h64, 32'd4); put32(64'h68, 32'h0); put32(64'h6C, 32'h80);
    model(64'h50);
    nstat = 0;
    reg_write(3'd0, 4'd8, 64'h50);
    chk(busy == 1'b1, "R11 busy during transfer", 64'(busy), 64'h1);
    reg_write(3'd0, 4'd8, 64'h60);
    reg_write(3'd4, 4'd4, 64'h60);
    wait_idle("R12 long transfer");
    repeat (6) @(negedge clk);
    chk(busy == 1'b0, "R12 no second transfer", 64'(busy), 64'h0);
    chk(nstat == 1, "R12 single status write", 64'(nstat), 64'h1);
    mem_cmp("R12 ignored start");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule